// File: doc/BRIEF.md
# Banked and Indirect Data Address Generator

This block forms the 12-bit data-memory address for an 8-bit core whose 4096-byte register file is split into sixteen 256-byte pages. For a direct operand it takes the 8-bit address field of the instruction and an access bit. When the access bit is clear, the field is sign-extended into a split window that covers the bottom and top 128 bytes. When it is set, the field is placed under a 4-bit page register that the block holds.

The block also keeps three 12-bit pointers. Each pointer answers at five alias addresses, and each alias picks an indirect mode: plain, post-decrement, post-increment, pre-increment, or offset by the unsigned accumulator W. An access that lands on an alias is redirected to the address the pointer yields, and the pointer is updated at the clock edge. Software can also load a whole pointer from a 12-bit literal in one cycle, and can write or read each pointer one byte at a time. A pointer that aims at an alias address cannot be followed. That access reads as zero, and neither the write nor the pointer update takes place.

Top module: `dag_top`

## Requirements
- R1: With `acc_bank_i`=0 the page register is ignored. Fields 0x00-0x7F give addresses 0x000-0x07F, and fields 0x80-0xFF give 0xF80-0xFFF (a sign extension of the field).
- R2: With `acc_bank_i`=1 the address is {page, field}. The page register is written from `bank_wdata_i` when `bank_we_i` is high, and the new value applies from the next cycle.
- R3: Plain mode (alias offset 0) puts the pointer value on `addr_o` and leaves the pointer unchanged.
- R4: Post-decrement mode (offset 1) puts the pointer value on `addr_o`, then decrements the pointer modulo 4096.
- R5: Post-increment mode (offset 2) puts the pointer value on `addr_o`, then increments the pointer modulo 4096.
- R6: Pre-increment mode (offset 3) puts pointer+1 on `addr_o` and stores pointer+1.
- R7: W-offset mode (offset 4) puts (pointer + unsigned W) mod 4096 on `addr_o` and leaves the pointer unchanged.
- R8: `ld_valid_i` writes `ld_lit_i` into pointer `ld_sel_i` at the next edge. This load takes priority over a byte write and over a mode update to the same pointer in the same cycle.
- R9: A byte write with `bw_hi_i`=0 sets pointer bits 7:0. With `bw_hi_i`=1 it sets bits 11:8 from data bits 3:0, and data bits 7:4 are ignored. `ptr_byte_o` returns the low byte, or {4'b0, bits 11:8} when `rd_hi_i`=1.
- R10: An indirect access whose resulting address is itself an alias raises `rd_zero_o`, keeps `wr_en_o` low and leaves the pointer unchanged.
- R11: After reset the page register and all pointers are zero.
- R12: Pointer n, mode m, answers at address 0xFD0 + 8n + m for m in 0..4. Offsets 5-7 in each 8-byte slot are ordinary addresses: they pass through unchanged, and a write to them is enabled.
- R13: With `acc_valid_i`=0 no pointer changes and `wr_en_o` and `rd_zero_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_we_i | input | 1 | Page register write enable |
| bank_wdata_i | input | 4 | New page value |
| acc_valid_i | input | 1 | Data access this cycle |
| acc_bank_i | input | 1 | Access bit: 1 selects the paged address |
| acc_field_i | input | 8 | Instruction address field |
| acc_write_i | input | 1 | The access writes memory |
| w_i | input | 8 | Accumulator value for W-offset mode |
| ld_valid_i | input | 1 | Load a pointer from the literal |
| ld_sel_i | input | 2 | Pointer chosen for the literal load |
| ld_lit_i | input | 12 | Literal pointer value |
| bw_valid_i | input | 1 | Pointer byte write |
| bw_sel_i | input | 2 | Pointer chosen for the byte write |
| bw_hi_i | input | 1 | Byte write targets bits 11:8 |
| bw_data_i | input | 8 | Byte write data |
| rd_sel_i | input | 2 | Pointer chosen for the byte read |
| rd_hi_i | input | 1 | Byte read returns the high part |
| addr_o | output | 12 | Resolved data-memory address |
| wr_en_o | output | 1 | Memory write allowed |
| rd_zero_o | output | 1 | Access blocked; read data must be zero |
| ptr_byte_o | output | 8 | Byte read from the chosen pointer |

## Verification
Pointer state is held internally, and a wrong value there appears at the ports in one of two ways. The next indirect access through any alias of that pointer puts it on `addr_o` in the same cycle. The byte read port shows it right after the edge that wrote it. For this reason every mode test checks both the address during the access and the pointer one edge later. A wrong mode update or a missed priority shows up within one cycle. A block that fails to recurse-protect would show an enabled write or a moved pointer on the blocked access itself.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned PAGE_W  = 4;
  localparam int unsigned ADDR_W  = FIELD_W + PAGE_W;
  localparam int unsigned SLOT_W  = 3;

  typedef enum logic [SLOT_W-1:0] {
    MODE_PLAIN   = 3'd0,
    MODE_POSTDEC = 3'd1,
    MODE_POSTINC = 3'd2,
    MODE_PREINC  = 3'd3,
    MODE_WOFF    = 3'd4
  } ind_mode_e;
endpackage

// File: rtl/dag_direct.sv
module dag_direct
  import dag_pkg::*;
(
  input  logic [PAGE_W-1:0]  page_i,
  input  logic               use_page_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic [ADDR_W-1:0]  addr_o
);
  always_comb begin
    if (use_page_i) addr_o = {page_i, field_i};
    else            addr_o = {{PAGE_W{field_i[FIELD_W-1]}}, field_i};
  end
endmodule

// File: rtl/dag_alias_dec.sv
module dag_alias_dec
  import dag_pkg::*;
#(
  parameter int unsigned        NPTR       = 3,
  parameter logic [ADDR_W-1:0]  ALIAS_BASE = 12'hFD0,
  localparam int unsigned       IW         = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IW-1:0]     idx_o,
  output ind_mode_e         mode_o
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NPTR << SLOT_W);

  logic [ADDR_W-1:0] off;
  logic              in_rng;

  always_comb begin
    off    = addr_i - ALIAS_BASE;
    in_rng = (addr_i >= ALIAS_BASE) && (off < SPAN);
    idx_o  = off[SLOT_W +: IW];
    mode_o = ind_mode_e'(off[SLOT_W-1:0]);
    hit_o  = in_rng && (off[SLOT_W-1:0] <= 3'd4);
  end
endmodule

// File: rtl/dag_ptr_file.sv
module dag_ptr_file
  import dag_pkg::*;
#(
  parameter int unsigned  NPTR = 3,
  localparam int unsigned IW   = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ld_valid_i,
  input  logic [IW-1:0]          ld_sel_i,
  input  logic [ADDR_W-1:0]      ld_lit_i,
  input  logic                   bw_valid_i,
  input  logic [IW-1:0]          bw_sel_i,
  input  logic                   bw_hi_i,
  input  logic [FIELD_W-1:0]     bw_data_i,
  input  logic                   upd_valid_i,
  input  logic [IW-1:0]          upd_sel_i,
  input  logic [ADDR_W-1:0]      upd_val_i,
  input  logic [IW-1:0]          rd_sel_i,
  input  logic                   rd_hi_i,
  output logic [FIELD_W-1:0]     rd_byte_o,
  output logic [NPTR*ADDR_W-1:0] ptr_flat_o
);
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic [ADDR_W-1:0] ptr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q <= '0;
      end else if (ld_valid_i && ld_sel_i == IW'(g)) begin
        ptr_q <= ld_lit_i;
      end else if (bw_valid_i && bw_sel_i == IW'(g)) begin
        if (bw_hi_i) ptr_q[ADDR_W-1:FIELD_W] <= bw_data_i[PAGE_W-1:0];
        else         ptr_q[FIELD_W-1:0]      <= bw_data_i;
      end else if (upd_valid_i && upd_sel_i == IW'(g)) begin
        ptr_q <= upd_val_i;
      end
    end
    assign ptr_flat_o[g*ADDR_W +: ADDR_W] = ptr_q;
  end

  logic [ADDR_W-1:0] rd_ptr;
  always_comb begin
    rd_ptr = '0;
    if (int'(rd_sel_i) < NPTR) rd_ptr = ptr_flat_o[int'(rd_sel_i)*ADDR_W +: ADDR_W];
    rd_byte_o = rd_hi_i ? FIELD_W'(rd_ptr[ADDR_W-1:FIELD_W]) : rd_ptr[FIELD_W-1:0];
  end
endmodule

// File: rtl/dag_top.sv
module dag_top
  import dag_pkg::*;
#(
  parameter int unsigned        NPTR       = 3,
  parameter logic [ADDR_W-1:0]  ALIAS_BASE = 12'hFD0,
  localparam int unsigned       IW         = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bank_we_i,
  input  logic [PAGE_W-1:0]  bank_wdata_i,
  input  logic               acc_valid_i,
  input  logic               acc_bank_i,
  input  logic [FIELD_W-1:0] acc_field_i,
  input  logic               acc_write_i,
  input  logic [FIELD_W-1:0] w_i,
  input  logic               ld_valid_i,
  input  logic [IW-1:0]      ld_sel_i,
  input  logic [ADDR_W-1:0]  ld_lit_i,
  input  logic               bw_valid_i,
  input  logic [IW-1:0]      bw_sel_i,
  input  logic               bw_hi_i,
  input  logic [FIELD_W-1:0] bw_data_i,
  input  logic [IW-1:0]      rd_sel_i,
  input  logic               rd_hi_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               wr_en_o,
  output logic               rd_zero_o,
  output logic [FIELD_W-1:0] ptr_byte_o
);
  logic [PAGE_W-1:0]      page_q;
  logic [ADDR_W-1:0]      dir_addr, cur_ptr, tgt_addr, new_ptr;
  logic [NPTR*ADDR_W-1:0] ptr_flat;
  logic                   alias_hit, tgt_hit, blocked, moves;
  logic [IW-1:0]          alias_idx, tgt_idx;
  ind_mode_e              alias_mode, tgt_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        page_q <= '0;
    else if (bank_we_i) page_q <= bank_wdata_i;
  end

  dag_direct u_direct (
    .page_i     (page_q),
    .use_page_i (acc_bank_i),
    .field_i    (acc_field_i),
    .addr_o     (dir_addr)
  );

  dag_alias_dec #(.NPTR(NPTR), .ALIAS_BASE(ALIAS_BASE)) u_dec_src (
    .addr_i (dir_addr),
    .hit_o  (alias_hit),
    .idx_o  (alias_idx),
    .mode_o (alias_mode)
  );

  always_comb begin
    cur_ptr = '0;
    if (int'(alias_idx) < NPTR) cur_ptr = ptr_flat[int'(alias_idx)*ADDR_W +: ADDR_W];
    tgt_addr = cur_ptr;
    new_ptr  = cur_ptr;
    moves    = 1'b0;
    unique case (alias_mode)
      MODE_POSTDEC: begin new_ptr = cur_ptr - ADDR_W'(1); moves = 1'b1; end
      MODE_POSTINC: begin new_ptr = cur_ptr + ADDR_W'(1); moves = 1'b1; end
      MODE_PREINC: begin
        new_ptr  = cur_ptr + ADDR_W'(1);
        tgt_addr = new_ptr;
        moves    = 1'b1;
      end
      MODE_WOFF: tgt_addr = cur_ptr + ADDR_W'(w_i);
      default: ;
    endcase
  end

  // second decode catches a pointer that aims back into the alias window
  dag_alias_dec #(.NPTR(NPTR), .ALIAS_BASE(ALIAS_BASE)) u_dec_tgt (
    .addr_i (tgt_addr),
    .hit_o  (tgt_hit),
    .idx_o  (tgt_idx),
    .mode_o (tgt_mode)
  );

  logic tgt_unused;
  assign tgt_unused = ^{tgt_idx, tgt_mode};

  assign blocked   = alias_hit && tgt_hit;
  assign addr_o    = alias_hit ? tgt_addr : dir_addr;
  assign rd_zero_o = acc_valid_i && blocked;
  assign wr_en_o   = acc_valid_i && acc_write_i && !blocked;

  dag_ptr_file #(.NPTR(NPTR)) u_ptrs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_valid_i  (ld_valid_i),
    .ld_sel_i    (ld_sel_i),
    .ld_lit_i    (ld_lit_i),
    .bw_valid_i  (bw_valid_i),
    .bw_sel_i    (bw_sel_i),
    .bw_hi_i     (bw_hi_i),
    .bw_data_i   (bw_data_i),
    .upd_valid_i (acc_valid_i && alias_hit && !blocked && moves),
    .upd_sel_i   (alias_idx),
    .upd_val_i   (new_ptr),
    .rd_sel_i    (rd_sel_i),
    .rd_hi_i     (rd_hi_i),
    .rd_byte_o   (ptr_byte_o),
    .ptr_flat_o  (ptr_flat)
  );
endmodule

// File: rtl/dag_checker.sv
module dag_checker
  import dag_pkg::*;
#(
  parameter int unsigned  NPTR = 3,
  localparam int unsigned IW   = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   acc_valid_i,
  input logic                   acc_bank_i,
  input logic [FIELD_W-1:0]     acc_field_i,
  input logic                   acc_write_i,
  input logic                   ld_valid_i,
  input logic [IW-1:0]          ld_sel_i,
  input logic [ADDR_W-1:0]      ld_lit_i,
  input logic                   bw_valid_i,
  input logic [ADDR_W-1:0]      addr_o,
  input logic                   wr_en_o,
  input logic                   rd_zero_o,
  input logic                   alias_hit,
  input logic [SLOT_W-1:0]      alias_mode,
  input logic [NPTR*ADDR_W-1:0] ptr_flat
);
  AST_LOW_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_bank_i && !acc_field_i[FIELD_W-1]) |-> addr_o == ADDR_W'(acc_field_i)); // R1

  AST_PLAIN_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && alias_hit && alias_mode == 3'd0 && !ld_valid_i && !bw_valid_i)
    |=> $stable(ptr_flat)); // R3

  AST_WOFF_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && alias_hit && alias_mode == 3'd4 && !ld_valid_i && !bw_valid_i)
    |=> $stable(ptr_flat)); // R7

  AST_LOAD_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && int'(ld_sel_i) < NPTR)
    |=> ptr_flat[int'($past(ld_sel_i))*ADDR_W +: ADDR_W] == $past(ld_lit_i)); // R8

  AST_BLOCK_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_zero_o |-> !wr_en_o); // R10

  AST_BLOCK_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_zero_o && !ld_valid_i && !bw_valid_i) |=> $stable(ptr_flat)); // R10

  AST_IDLE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_valid_i && !ld_valid_i && !bw_valid_i) |=> $stable(ptr_flat)); // R13

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> (!wr_en_o && !rd_zero_o)); // R13

  AST_WRITE_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (acc_valid_i && acc_write_i)); // R12
endmodule

bind dag_top dag_checker #(.NPTR(NPTR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_bank_i  (acc_bank_i),
  .acc_field_i (acc_field_i),
  .acc_write_i (acc_write_i),
  .ld_valid_i  (ld_valid_i),
  .ld_sel_i    (ld_sel_i),
  .ld_lit_i    (ld_lit_i),
  .bw_valid_i  (bw_valid_i),
  .addr_o      (addr_o),
  .wr_en_o     (wr_en_o),
  .rd_zero_o   (rd_zero_o),
  .alias_hit   (alias_hit),
  .alias_mode  (alias_mode),
  .ptr_flat    (ptr_flat)
);

// File: tb/tb_dag_top.sv
`timescale 1ns/1ps
module tb_dag_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bank_we_i = 0;
  logic [3:0]  bank_wdata_i = '0;
  logic        acc_valid_i = 0, acc_bank_i = 0, acc_write_i = 0;
  logic [7:0]  acc_field_i = '0, w_i = '0;
  logic        ld_valid_i = 0;
  logic [1:0]  ld_sel_i = '0;
  logic [11:0] ld_lit_i = '0;
  logic        bw_valid_i = 0, bw_hi_i = 0;
  logic [1:0]  bw_sel_i = '0, rd_sel_i = '0;
  logic [7:0]  bw_data_i = '0;
  logic        rd_hi_i = 0;
  logic [11:0] addr_o;
  logic        wr_en_o, rd_zero_o;
  logic [7:0]  ptr_byte_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  dag_top dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic read_ptr(input int idx, output logic [11:0] v);
    rd_sel_i = 2'(idx); rd_hi_i = 1'b1; #1;
    v[11:8] = ptr_byte_o[3:0];
    check(ptr_byte_o[7:4] == 4'h0, "R9", ptr_byte_o, {4'h0, ptr_byte_o[3:0]});
    rd_hi_i = 1'b0; #1;
    v[7:0] = ptr_byte_o;
  endtask

  task automatic check_ptr(input int idx, input logic [11:0] exp, input string req);
    logic [11:0] v;
    read_ptr(idx, v);
    check(v == exp, req, v, exp);
  endtask

  task automatic access(input logic a, input logic [7:0] f, input logic wr, input logic [7:0] w,
                        output logic [11:0] ad, output logic we, output logic rz);
    @(negedge clk_i);
    acc_valid_i = 1; acc_bank_i = a; acc_field_i = f; acc_write_i = wr; w_i = w;
    #1; ad = addr_o; we = wr_en_o; rz = rd_zero_o;
    @(posedge clk_i); #1;
    acc_valid_i = 0; acc_write_i = 0;
  endtask

  task automatic load(input int idx, input logic [11:0] lit);
    @(negedge clk_i);
    ld_valid_i = 1; ld_sel_i = 2'(idx); ld_lit_i = lit;
    @(posedge clk_i); #1; ld_valid_i = 0;
  endtask

  task automatic byte_wr(input int idx, input logic hi, input logic [7:0] d);
    @(negedge clk_i);
    bw_valid_i = 1; bw_sel_i = 2'(idx); bw_hi_i = hi; bw_data_i = d;
    @(posedge clk_i); #1; bw_valid_i = 0;
  endtask

  task automatic t_reset();
    logic [11:0] ad; logic we, rz;
    for (int i = 0; i < 3; i++) check_ptr(i, 12'h000, "R11");
    access(1'b1, 8'h12, 1'b0, 8'h0, ad, we, rz);
    check(ad == 12'h012, "R11", ad, 12'h012);
  endtask

  task automatic t_direct();
    logic [11:0] ad; logic we, rz;
    access(1'b0, 8'h7F, 1'b0, 8'h0, ad, we, rz); check(ad == 12'h07F, "R1", ad, 12'h07F);
    access(1'b0, 8'h80, 1'b0, 8'h0, ad, we, rz); check(ad == 12'hF80, "R1", ad, 12'hF80);
    access(1'b0, 8'hFF, 1'b1, 8'h0, ad, we, rz); check(ad == 12'hFFF, "R1", ad, 12'hFFF);
    check(we == 1'b1, "R12", we, 1);
    @(negedge clk_i); bank_we_i = 1; bank_wdata_i = 4'hA;
    @(posedge clk_i); #1; bank_we_i = 0;
    access(1'b1, 8'h34, 1'b0, 8'h0, ad, we, rz); check(ad == 12'hA34, "R2", ad, 12'hA34);
    access(1'b0, 8'h34, 1'b0, 8'h0, ad, we, rz); check(ad == 12'h034, "R1", ad, 12'h034);
  endtask

  task automatic t_plain();
    logic [11:0] ad; logic we, rz;
    load(0, 12'h123); check_ptr(0, 12'h123, "R8");
    access(1'b0, 8'hD0, 1'b1, 8'h0, ad, we, rz);
    check(ad == 12'h123, "R3", ad, 12'h123);
    check(we == 1'b1 && rz == 1'b0, "R3", {we, rz}, 2'b10);
    check_ptr(0, 12'h123, "R3");
  endtask

  task automatic t_postdec();
    logic [11:0] ad; logic we, rz;
    load(1, 12'h000);
    access(1'b0, 8'hD9, 1'b0, 8'h0, ad, we, rz);
    check(ad == 12'h000, "R4", ad, 12'h000);
    check_ptr(1, 12'hFFF, "R4");
  endtask

  task automatic t_postinc();
    logic [11:0] ad; logic we, rz;
    load(2, 12'hFFF);
    access(1'b0, 8'hE2, 1'b0, 8'h0, ad, we, rz);
    check(ad == 12'hFFF, "R5", ad, 12'hFFF);
    check_ptr(2, 12'h000, "R5");
  endtask

  task automatic t_preinc();
    logic [11:0] ad; logic we, rz;
    access(1'b0, 8'hD3, 1'b0, 8'h0, ad, we, rz);
    check(ad == 12'h124, "R6", ad, 12'h124);
    check_ptr(0, 12'h124, "R6");
  endtask

  task automatic t_woff();
    logic [11:0] ad; logic we, rz;
    access(1'b0, 8'hDC, 1'b0, 8'h02, ad, we, rz);
    check(ad == 12'h001, "R7", ad, 12'h001);
    check_ptr(1, 12'hFFF, "R7");
    load(1, 12'h100);
    access(1'b0, 8'hDC, 1'b0, 8'hF0, ad, we, rz);
    check(ad == 12'h1F0, "R7", ad, 12'h1F0);
    check_ptr(1, 12'h100, "R7");
  endtask

  task automatic t_recursion();
    logic [11:0] ad; logic we, rz;
    load(2, 12'hFD1);
    access(1'b0, 8'hE0, 1'b1, 8'h0, ad, we, rz);
    check(rz == 1'b1 && we == 1'b0, "R10", {rz, we}, 2'b10);
    access(1'b0, 8'hE2, 1'b1, 8'h0, ad, we, rz);
    check(rz == 1'b1 && we == 1'b0, "R10", {rz, we}, 2'b10);
    check_ptr(2, 12'hFD1, "R10");
    load(2, 12'hFCF);
    access(1'b0, 8'hE3, 1'b0, 8'h0, ad, we, rz);
    check(rz == 1'b1, "R10", rz, 1);
    check_ptr(2, 12'hFCF, "R10");
  endtask

  task automatic t_gap();
    logic [11:0] ad; logic we, rz;
    access(1'b0, 8'hD5, 1'b1, 8'h0, ad, we, rz);
    check(ad == 12'hFD5 && we && !rz, "R12", {ad, we, rz}, {12'hFD5, 2'b10});
    access(1'b0, 8'hE7, 1'b0, 8'h0, ad, we, rz);
    check(ad == 12'hFE7 && !rz, "R12", ad, 12'hFE7);
    check_ptr(0, 12'h124, "R12");
  endtask

  task automatic t_bytes();
    byte_wr(1, 1'b1, 8'h0B); check_ptr(1, 12'hB00, "R9");
    byte_wr(1, 1'b0, 8'h5A); check_ptr(1, 12'hB5A, "R9");
    byte_wr(1, 1'b1, 8'hF3); check_ptr(1, 12'h35A, "R9");
  endtask

  task automatic t_priority();
    @(negedge clk_i);
    acc_valid_i = 1; acc_bank_i = 0; acc_field_i = 8'hD2;
    ld_valid_i = 1; ld_sel_i = 2'd0; ld_lit_i = 12'h777;
    bw_valid_i = 1; bw_sel_i = 2'd0; bw_hi_i = 0; bw_data_i = 8'h11;
    @(posedge clk_i); #1;
    acc_valid_i = 0; ld_valid_i = 0; bw_valid_i = 0;
    check_ptr(0, 12'h777, "R8");
  endtask

  task automatic t_idle();
    @(negedge clk_i);
    acc_valid_i = 0; acc_bank_i = 0; acc_field_i = 8'hD2; acc_write_i = 1; #1;
    check(!wr_en_o && !rd_zero_o, "R13", {wr_en_o, rd_zero_o}, 0);
    @(posedge clk_i); #1; acc_write_i = 0;
    check_ptr(0, 12'h777, "R13");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1;
    t_reset();
    t_direct();
    t_plain();
    t_postdec();
    t_postinc();
    t_preinc();
    t_woff();
    t_recursion();
    t_gap();
    t_bytes();
    t_priority();
    t_idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule